// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two 8-bit buses, A and B, in a number of identical lanes (two by default). Every lane keeps a 9-bit transparent latch on each side. The latch holds eight data bits and one parity bit, and each side's latch opens or closes on its own. A direction state machine reads two active-low drive requests, one for each bus. From them it decides whether the A latch drives bus B, the B latch drives bus A, or neither bus is driven. Pads are modelled as separate input, output and output-enable ports.

The parity bit sent on the far bus is either passed through from the near latch unchanged or regenerated from the latched data bits. The odd/even select picks the parity sense. Both latches of every lane are checked for parity at all times, including while both buses float. Each check drives an active-low error flag, so a transmitter can generate parity and check both ends at the same time.

The direction state machine has four states. ST_FLOAT drives no bus. ST_A2B drives bus B. ST_B2A drives bus A. ST_FAULT drives no bus and raises the illegal flag. Transitions are taken on each clock edge from the drive requests:
- Only the B request low goes to ST_A2B.
- Only the A request low goes to ST_B2A.
- Both requests high go to ST_FLOAT.
- Both requests low go to ST_FAULT from any state.
- ST_FAULT is left only through reset.

Top module: `latched_parity_xcvr`

## Requirements
- R1: While reset is asserted and immediately after it, both bus output enables are 0, the illegal flag is 0 and both latches of every lane hold all zeros.
- R2: While a side's latch is open (`a_open`/`b_open` = 1), the data driven toward the opposite bus equals that side's input data in the same cycle.
- R3: While a side's latch is closed, it presents the 9 bits it captured at the last rising clock edge at which it was open, whatever the inputs do.
- R4: One clock edge after `b_drive_n`=0 and `a_drive_n`=1 are sampled outside ST_FAULT, `b_oe`=1 and `a_oe`=0 (A to B).
- R5: One clock edge after `a_drive_n`=0 and `b_drive_n`=1 are sampled outside ST_FAULT, `a_oe`=1 and `b_oe`=0 (B to A).
- R6: One clock edge after both drive requests are sampled high outside ST_FAULT, both output enables are 0. Both latches keep capturing independently.
- R7: With `parity_pass`=1, the parity bit sent to the far bus equals the near latch's parity bit.
- R8: With `parity_pass`=0, the parity bit sent equals the XOR of the near latch's 8 data bits XOR `odd_mode`. The sent 9 bits then hold an even count of ones (`odd_mode`=0) or an odd count (`odd_mode`=1).
- R9: Each `err_a_n`/`err_b_n` bit is 0 exactly when the parity of the 9 bits presented by that latch does not match the selected sense. This holds in every direction state.
- R10: Sampling both drive requests low moves to ST_FAULT on the next edge. In ST_FAULT `illegal`=1 and both enables are 0 until reset, whatever the drive requests are.
- R11: Lanes share the latch, drive, parity-mode and odd/even controls. Data, parity and error signals are separate for each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_drive_n | input | 1 | Request to drive bus A, active low |
| b_drive_n | input | 1 | Request to drive bus B, active low |
| a_open | input | 1 | A latch transparent when 1 |
| b_open | input | 1 | B latch transparent when 1 |
| parity_pass | input | 1 | 1 passes parity through, 0 regenerates it |
| odd_mode | input | 1 | 1 selects odd parity, 0 selects even |
| a_in | input | LANES*DW | Bus A data pad inputs, lane l at bits l*DW upward |
| a_par_in | input | LANES | Bus A parity pad inputs |
| a_out | output | LANES*DW | Bus A data pad outputs (from the B latch) |
| a_par_out | output | LANES | Bus A parity pad outputs |
| a_oe | output | 1 | Bus A pad output enable |
| b_in | input | LANES*DW | Bus B data pad inputs |
| b_par_in | input | LANES | Bus B parity pad inputs |
| b_out | output | LANES*DW | Bus B data pad outputs (from the A latch) |
| b_par_out | output | LANES | Bus B parity pad outputs |
| b_oe | output | 1 | Bus B pad output enable |
| err_a_n | output | LANES | A latch parity error for each lane, active low |
| err_b_n | output | LANES | B latch parity error for each lane, active low |
| illegal | output | 1 | Sticky flag for both drive requests asserted |

## Verification
The assertions assume that all inputs change only between rising clock edges and that reset is asserted before the first edge. Under that assumption a latch's view and the sampled drive requests are well defined at every edge. The stimulus changes every input just after the falling edge and pulses reset only there. It still exercises every combination of drive requests, including the forbidden one after which ST_FAULT must persist.

// File: rtl/plt_pkg.sv
package plt_pkg;
    typedef enum logic [1:0] {
        ST_FLOAT = 2'd0,
        ST_A2B   = 2'd1,
        ST_B2A   = 2'd2,
        ST_FAULT = 2'd3
    } xfer_state_t;
endpackage

// File: rtl/plt_side_latch.sv
module plt_side_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open,
    input  logic [DW-1:0] d_in,
    input  logic          p_in,
    input  logic          odd_mode,
    output logic [DW-1:0] d_view,
    output logic          p_view,
    output logic          err_n
);
    localparam int LW = DW + 1;

    logic [LW-1:0] held;
    logic [LW-1:0] view;

    // transparent path when open, captured copy when closed
    always_comb begin
        view = open ? {p_in, d_in} : held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held <= '0;
        else        held <= view;
    end

    assign d_view = view[DW-1:0];
    assign p_view = view[DW];
    assign err_n  = ~((^view) ^ odd_mode);

    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> (open || ({p_view, d_view} == $past({p_view, d_view})))); // R3
endmodule

// File: rtl/plt_lane.sv
module plt_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_open,
    input  logic          b_open,
    input  logic          parity_pass,
    input  logic          odd_mode,
    input  logic [DW-1:0] a_in,
    input  logic          a_par_in,
    input  logic [DW-1:0] b_in,
    input  logic          b_par_in,
    output logic [DW-1:0] a_out,
    output logic          a_par_out,
    output logic [DW-1:0] b_out,
    output logic          b_par_out,
    output logic          err_a_n,
    output logic          err_b_n
);
    logic [DW-1:0] a_dv, b_dv;
    logic          a_pv, b_pv;

    plt_side_latch #(.DW(DW)) u_a_side (
        .clk(clk), .rst_n(rst_n), .open(a_open), .d_in(a_in), .p_in(a_par_in),
        .odd_mode(odd_mode), .d_view(a_dv), .p_view(a_pv), .err_n(err_a_n)
    );

    plt_side_latch #(.DW(DW)) u_b_side (
        .clk(clk), .rst_n(rst_n), .open(b_open), .d_in(b_in), .p_in(b_par_in),
        .odd_mode(odd_mode), .d_view(b_dv), .p_view(b_pv), .err_n(err_b_n)
    );

    // outgoing parity: pass the latched bit or regenerate from latched data
    always_comb begin
        b_out     = a_dv;
        a_out     = b_dv;
        b_par_out = parity_pass ? a_pv : ((^a_dv) ^ odd_mode);
        a_par_out = parity_pass ? b_pv : ((^b_dv) ^ odd_mode);
    end

    AST_GEN_B_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_pass |-> ((^{b_par_out, b_out}) == odd_mode)); // R8
    AST_GEN_A_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_pass |-> ((^{a_par_out, a_out}) == odd_mode)); // R8
    AST_PASS_B_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_pass && a_open) |-> (b_par_out == a_par_in)); // R7
    AST_OPEN_B_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        a_open |-> (b_out == a_in)); // R2
endmodule

// File: rtl/plt_dir_fsm.sv
module plt_dir_fsm
    import plt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_drive_n,
    input  logic b_drive_n,
    output logic a_oe,
    output logic b_oe,
    output logic illegal
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLOAT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOAT, ST_A2B, ST_B2A: begin
                unique case ({a_drive_n, b_drive_n})
                    2'b00: state_d = ST_FAULT;
                    2'b10: state_d = ST_A2B;
                    2'b01: state_d = ST_B2A;
                    2'b11: state_d = ST_FLOAT;
                endcase
            end
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    always_comb begin
        a_oe    = 1'b0;
        b_oe    = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_FLOAT: ;
            ST_A2B:   b_oe = 1'b1;
            ST_B2A:   a_oe = 1'b1;
            ST_FAULT: illegal = 1'b1;
        endcase
    end

    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe)); // R10
    AST_FAULT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_drive_n && !b_drive_n) |=> illegal); // R10
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (illegal && !a_oe && !b_oe)); // R10
    AST_A2B_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && a_drive_n && !b_drive_n) |=> (b_oe && !a_oe)); // R4
    AST_B2A_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && !a_drive_n && b_drive_n) |=> (a_oe && !b_oe)); // R5
    AST_FLOAT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && a_drive_n && b_drive_n) |=> (!a_oe && !b_oe)); // R6
endmodule

// File: rtl/latched_parity_xcvr.sv
module latched_parity_xcvr #(
    parameter int DW    = 8,
    parameter int LANES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_drive_n,
    input  logic                b_drive_n,
    input  logic                a_open,
    input  logic                b_open,
    input  logic                parity_pass,
    input  logic                odd_mode,
    input  logic [LANES*DW-1:0] a_in,
    input  logic [LANES-1:0]    a_par_in,
    output logic [LANES*DW-1:0] a_out,
    output logic [LANES-1:0]    a_par_out,
    output logic                a_oe,
    input  logic [LANES*DW-1:0] b_in,
    input  logic [LANES-1:0]    b_par_in,
    output logic [LANES*DW-1:0] b_out,
    output logic [LANES-1:0]    b_par_out,
    output logic                b_oe,
    output logic [LANES-1:0]    err_a_n,
    output logic [LANES-1:0]    err_b_n,
    output logic                illegal
);
    plt_dir_fsm u_dir (
        .clk(clk), .rst_n(rst_n), .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
        .a_oe(a_oe), .b_oe(b_oe), .illegal(illegal)
    );

    // R11: one lane per slice, shared controls
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        plt_lane #(.DW(DW)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .a_open(a_open), .b_open(b_open),
            .parity_pass(parity_pass), .odd_mode(odd_mode),
            .a_in(a_in[l*DW +: DW]), .a_par_in(a_par_in[l]),
            .b_in(b_in[l*DW +: DW]), .b_par_in(b_par_in[l]),
            .a_out(a_out[l*DW +: DW]), .a_par_out(a_par_out[l]),
            .b_out(b_out[l*DW +: DW]), .b_par_out(b_par_out[l]),
            .err_a_n(err_a_n[l]), .err_b_n(err_b_n[l])
        );
    end
endmodule

// File: tb/test_latched_parity_xcvr.sv
module test_latched_parity_xcvr;
    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int LANES  = 2;
    localparam int BW     = LANES * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_drive_n = 1'b1, b_drive_n = 1'b1;
    logic a_open = 1'b0, b_open = 1'b0, parity_pass = 1'b0, odd_mode = 1'b0;
    logic [BW-1:0] a_in = '0, b_in = '0;
    logic [LANES-1:0] a_par_in = '0, b_par_in = '0;
    logic [BW-1:0] a_out, b_out;
    logic [LANES-1:0] a_par_out, b_par_out, err_a_n, err_b_n;
    logic a_oe, b_oe, illegal;

    latched_parity_xcvr #(.DW(DW), .LANES(LANES)) i_latched_parity_xcvr (
        .clk(clk), .rst_n(rst_n), .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
        .a_open(a_open), .b_open(b_open), .parity_pass(parity_pass), .odd_mode(odd_mode),
        .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_b_n(err_b_n), .illegal(illegal)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // behavioural reference: held words per side and lane, direction as integer
    // direction code: 0 none, 1 A to B, 2 B to A, 3 fault
    logic [DW:0] m_ha [LANES];
    logic [DW:0] m_hb [LANES];
    int m_dir = 0;

    function automatic int ones(logic [DW:0] v);
        int c = 0;
        for (int i = 0; i <= DW; i++) if (v[i]) c++;
        return c;
    endfunction

    function automatic logic [DW:0] va(int l);
        return a_open ? {a_par_in[l], a_in[l*DW +: DW]} : m_ha[l];
    endfunction

    function automatic logic [DW:0] vb(int l);
        return b_open ? {b_par_in[l], b_in[l*DW +: DW]} : m_hb[l];
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < LANES; l++) begin
            m_ha[l] = '0;
            m_hb[l] = '0;
        end
        m_dir = 0;
    endtask

    task automatic compare_all();
        string dtag;
        string otag;
        otag = (m_dir == 1) ? "R4 oe" : (m_dir == 2) ? "R5 oe" : (m_dir == 3) ? "R10 oe" : "R6 oe";
        chk(otag, 32'(a_oe), (m_dir == 2) ? 1 : 0);
        chk(otag, 32'(b_oe), (m_dir == 1) ? 1 : 0);
        chk("R10 illegal", 32'(illegal), (m_dir == 3) ? 1 : 0);
        for (int l = 0; l < LANES; l++) begin
            logic [DW:0] xa, xb;
            int ga, gb;
            xa = va(l);
            xb = vb(l);
            // R11: each lane compared on its own
            dtag = a_open ? "R2 R11 b_out" : "R3 R11 b_out";
            chk(dtag, 32'(b_out[l*DW +: DW]), 32'(xa[DW-1:0]));
            dtag = b_open ? "R2 R11 a_out" : "R3 R11 a_out";
            chk(dtag, 32'(a_out[l*DW +: DW]), 32'(xb[DW-1:0]));
            ga = ((ones({1'b0, xa[DW-1:0]}) % 2) != 0) ? 1 : 0;
            gb = ((ones({1'b0, xb[DW-1:0]}) % 2) != 0) ? 1 : 0;
            if (odd_mode) begin ga = 1 - ga; gb = 1 - gb; end
            chk(parity_pass ? "R7 b_par" : "R8 b_par", 32'(b_par_out[l]), parity_pass ? 32'(xa[DW]) : ga);
            chk(parity_pass ? "R7 a_par" : "R8 a_par", 32'(a_par_out[l]), parity_pass ? 32'(xb[DW]) : gb);
            chk("R9 err_a", 32'(err_a_n[l]), ((ones(xa) % 2) == 32'(odd_mode)) ? 1 : 0);
            chk("R9 err_b", 32'(err_b_n[l]), ((ones(xb) % 2) == 32'(odd_mode)) ? 1 : 0);
        end
    endtask

    // called just after a falling edge with inputs already set
    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            for (int l = 0; l < LANES; l++) begin
                m_ha[l] = va(l);
                m_hb[l] = vb(l);
            end
            if (m_dir != 3) begin
                if (!a_drive_n && !b_drive_n) m_dir = 3;
                else if (!b_drive_n)          m_dir = 1;
                else if (!a_drive_n)          m_dir = 2;
                else                          m_dir = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic rand_data();
        a_in = BW'($urandom);
        b_in = BW'($urandom);
        a_par_in = LANES'($urandom);
        b_par_in = LANES'($urandom);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1: reset state at the ports
        chk("R1 a_oe", 32'(a_oe), 0);
        chk("R1 b_oe", 32'(b_oe), 0);
        chk("R1 illegal", 32'(illegal), 0);
        chk("R1 held zero b_out", 32'(b_out), 0);
        chk("R1 held zero err_a", 32'(err_a_n), 3);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // A to B, regenerate parity, both latches open
        a_drive_n = 1'b1; b_drive_n = 1'b0; a_open = 1; b_open = 1; parity_pass = 0;
        for (int i = 0; i < 20; i++) begin rand_data(); odd_mode = 1'($urandom); tick(); end
        // feed through
        parity_pass = 1;
        for (int i = 0; i < 20; i++) begin rand_data(); odd_mode = 1'($urandom); tick(); end
        // B to A with latches toggling
        a_drive_n = 1'b0; b_drive_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            rand_data(); a_open = 1'($urandom); b_open = 1'($urandom);
            parity_pass = 1'($urandom); odd_mode = 1'($urandom); tick();
        end
        // both floating: capture and checking continue (R6, R9)
        a_drive_n = 1'b1; b_drive_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            rand_data(); a_open = 1'($urandom); b_open = 1'($urandom);
            parity_pass = 1'($urandom); odd_mode = 1'($urandom); tick();
        end
        // R3: load then hold through changing inputs
        a_drive_n = 1'b1; b_drive_n = 1'b0; a_open = 1; b_open = 1;
        rand_data(); tick();
        a_open = 0; b_open = 0;
        for (int i = 0; i < 6; i++) begin rand_data(); parity_pass = 1'($urandom); tick(); end
        // R10: forbidden request, then normal request must not leave fault
        a_drive_n = 1'b0; b_drive_n = 1'b0;
        for (int i = 0; i < 4; i++) begin rand_data(); a_open = 1'($urandom); tick(); end
        a_drive_n = 1'b1; b_drive_n = 1'b0;
        for (int i = 0; i < 4; i++) begin rand_data(); tick(); end
        a_drive_n = 1'b0; b_drive_n = 1'b1;
        for (int i = 0; i < 4; i++) begin rand_data(); tick(); end
        // reset clears the fault, R1 again
        rst_n = 1'b0;
        model_reset();
        #1;
        chk("R1 illegal cleared", 32'(illegal), 0);
        tick();
        rst_n = 1'b1;
        a_drive_n = 1'b1; b_drive_n = 1'b0; a_open = 1; b_open = 0;
        for (int i = 0; i < 10; i++) begin rand_data(); odd_mode = 1'($urandom); tick(); end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule